// File: doc/BRIEF.md
# Multi-Port Receive Timestamp Latch

This block measures how long a frame takes to travel across a chain of fieldbus nodes. It sits in a node with four ports and watches one frame-start strobe per port. A register write to the port-0 receive time address arms a measurement. From then on, each port latches the running system time the first time a frame starts on it. Later frames on the same port leave the latched value alone until the unit is armed again.

Software reads the four latched times and a status word back through a small register port. From the differences between the ports and between nodes it works out the link delays. Frame decoding and the delay arithmetic live elsewhere. A write carries no data: the address alone selects the action.

Top module: `rxts_latch`

## Requirements
- R1: After reset, every port timestamp reads as 0 and the status word reads as 0.
- R2: Before the first arming write, frame-start strobes change neither a timestamp nor a status bit.
- R3: A write to address 0 arms the unit and clears all four valid flags on the same clock edge. The status word (address 4) carries the valid flag of port i in bit i and the armed flag in bit 4. Once set, the armed flag stays set until reset.
- R4: While armed, the first strobe on port i stores the `sys_time` value present in that cycle into the timestamp of port i (address i) and sets valid bit i.
- R5: While valid bit i is set, further strobes on port i leave its timestamp unchanged until the next arming write.
- R6: A strobe in the same cycle as the arming write is captured for the new measurement, overwriting the old value.
- R7: The ports capture independently. Strobes on several ports in one cycle store the same time in each of them.
- R8: A write to any address other than 0 has no effect on the arming state, the flags or the timestamps.
- R9: A read returns data in the cycle after `rd_en`, with `rd_valid` high for that one cycle. The data is the state before that edge: addresses 0 to 3 give the timestamps, address 4 gives the status word, and addresses 5 to 7 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_time | input | 32 | Running system time |
| rx_sof | input | 4 | Per-port frame-start strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 arms) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
The bench goes after a strobe that lands on the arming edge. A design that ignored it would read back a stale time with the valid bit clear. A design that captured it first and then cleared the flags would show the time but lose the valid bit. The bench repeats strobes on a port that has already captured, where an overwriting design returns a later time. It also writes to addresses other than 0, where a loose decode would re-arm the unit and wipe the flags. Random traffic mixes reads that fall on capture edges, so a design whose read path bypasses the registers would return the new value a cycle early.

// File: rtl/rxts_pkg.sv
package rxts_pkg;

  // Kind of register a read address resolves to.
  typedef enum logic [1:0] {
    SEL_STAMP  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_NONE   = 2'd2
  } rd_sel_e;

  // Address that arms a new measurement (port-0 timestamp).
  localparam int unsigned ARM_ADDR = 0;

endpackage

// File: rtl/rxts_port_cap.sv
module rxts_port_cap #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              armed,
  input  logic              strobe,
  input  logic [TIME_W-1:0] sys_time,
  output logic [TIME_W-1:0] stamp,
  output logic              valid
);

  logic take;

  // Capture on the arming edge itself, or later while the port is still open.
  assign take = strobe & (arm | (armed & ~valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp <= '0;
      valid <= 1'b0;
    end else begin
      if (take) stamp <= sys_time;
      if (arm)       valid <= strobe;
      else if (take) valid <= 1'b1;
    end
  end

  AST_HOLD_ONCE: assert property (@(posedge clk) disable iff (rst)
    (valid && !arm) |=> $stable(stamp)); // R5
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (arm && !strobe) |=> !valid); // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (strobe && (arm || (armed && !valid))) |=> (valid && stamp == $past(sys_time))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!armed && !arm) |=> ($stable(stamp) && !valid)); // R2

endmodule

// File: rtl/rxts_regif.sv
module rxts_regif
  import rxts_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int TIME_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [NPORTS-1:0][TIME_W-1:0] stamps,
  input  logic [NPORTS-1:0]             valids,
  input  logic                          armed,
  output logic                          arm,
  output logic [TIME_W-1:0]             rd_data,
  output logic                          rd_valid
);

  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NPORTS);
  localparam logic [ADDR_W-1:0] ARM_A     = ADDR_W'(ARM_ADDR);

  rd_sel_e           sel;
  logic [TIME_W-1:0] status_word;
  logic [TIME_W-1:0] rd_next;

  assign arm = wr_en && (wr_addr == ARM_A);

  always_comb begin
    status_word = '0;
    status_word[NPORTS-1:0] = valids;
    status_word[NPORTS]     = armed;
  end

  always_comb begin
    if (rd_addr < STAT_ADDR)       sel = SEL_STAMP;
    else if (rd_addr == STAT_ADDR) sel = SEL_STATUS;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_STAMP:  rd_next = stamps[rd_addr[PIDX_W-1:0]];
      SEL_STATUS: rd_next = status_word;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rd_valid && $stable(rd_data))); // R9

endmodule

// File: rtl/rxts_latch.sv
module rxts_latch #(
  parameter int NPORTS = 4,
  parameter int TIME_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] sys_time,
  input  logic [NPORTS-1:0] rx_sof,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [TIME_W-1:0] rd_data,
  output logic              rd_valid
);

  logic                          arm;
  logic                          armed;
  logic [NPORTS-1:0][TIME_W-1:0] stamps;
  logic [NPORTS-1:0]             valids;

  always_ff @(posedge clk) begin
    if (rst)      armed <= 1'b0;
    else if (arm) armed <= 1'b1;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    rxts_port_cap #(.TIME_W(TIME_W)) i_cap (
      .clk      (clk),
      .rst      (rst),
      .arm      (arm),
      .armed    (armed),
      .strobe   (rx_sof[p]),
      .sys_time (sys_time),
      .stamp    (stamps[p]),
      .valid    (valids[p])
    );
  end

  rxts_regif #(.NPORTS(NPORTS), .TIME_W(TIME_W), .ADDR_W(ADDR_W)) i_regif (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .stamps   (stamps),
    .valids   (valids),
    .armed    (armed),
    .arm      (arm),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R3
  AST_NOARM_OTHER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && !armed) |=> !armed); // R8
  AST_SAME_TIME: assert property (@(posedge clk) disable iff (rst)
    (arm && rx_sof[0] && rx_sof[NPORTS-1]) |=> (stamps[0] == stamps[NPORTS-1])); // R7

endmodule

// File: tb/test_rxts_latch.sv
module test_rxts_latch;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] sys_time;
  logic [3:0]  rx_sof;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic        rd_en;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid;

  int nvec = 0;
  int nbad = 0;

  logic [31:0] m_ts [4];
  logic [3:0]  m_valid;
  logic        m_armed;

  always #2 clk = ~clk;

  rxts_latch i_rxts_latch (
    .clk(clk), .rst(rst), .sys_time(sys_time), .rx_sof(rx_sof),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] model_read(input logic [2:0] a);
    if (a < 3'd4)  return m_ts[a];
    if (a == 3'd4) return {27'd0, m_armed, m_valid};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model, check after the rising edge.
  task automatic step(input logic [3:0] stb, input logic wr, input logic [2:0] wa,
                      input logic rd, input logic [2:0] ra, input string req);
    logic [31:0] exp;
    logic        arm;
    @(negedge clk);
    sys_time = $urandom;
    rx_sof = stb; wr_en = wr; wr_addr = wa; rd_en = rd; rd_addr = ra;
    exp = model_read(ra);
    arm = wr && (wa == 3'd0);
    for (int p = 0; p < 4; p++) begin
      if (stb[p] && (arm || (m_armed && !m_valid[p]))) m_ts[p] = sys_time;
      if (arm) m_valid[p] = stb[p];
      else if (stb[p] && m_armed) m_valid[p] = 1'b1;
    end
    if (arm) m_armed = 1'b1;
    @(posedge clk);
    #1;
    check({req, " rd_valid"}, {31'd0, rd_valid}, {31'd0, rd});
    if (rd) check(req, rd_data, exp);
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    step(4'b0, 1'b0, 3'd0, 1'b1, a, req);
  endtask

  initial begin
    #(4 * 150000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] t_a;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; sys_time = '0; rx_sof = '0; wr_en = 0; wr_addr = 0; rd_en = 0; rd_addr = 0;
    for (int p = 0; p < 4; p++) m_ts[p] = '0;
    m_valid = '0; m_armed = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), "R1");
    // R2 strobes before arming are ignored
    step(4'hF, 1'b0, 3'd0, 1'b0, 3'd0, "R2");
    rd(3'd4, "R2"); rd(3'd1, "R2");
    // R8 writes elsewhere do not arm
    step(4'b0, 1'b1, 3'd4, 1'b0, 3'd0, "R8");
    step(4'hF, 1'b1, 3'd6, 1'b0, 3'd0, "R8");
    rd(3'd4, "R8"); rd(3'd3, "R8");
    // R3 arm alone
    step(4'b0, 1'b1, 3'd0, 1'b0, 3'd0, "R3");
    rd(3'd4, "R3");
    // R4 first capture on port 2
    step(4'b0100, 1'b0, 3'd0, 1'b0, 3'd0, "R4");
    rd(3'd2, "R4"); rd(3'd4, "R4");
    // R5 second strobe does not overwrite
    step(4'b0100, 1'b0, 3'd0, 1'b0, 3'd0, "R5");
    rd(3'd2, "R5");
    // R8 write to status address keeps flags
    step(4'b0, 1'b1, 3'd4, 1'b0, 3'd0, "R8");
    rd(3'd4, "R8");
    // R6 strobe on the arming edge, R3 other flags cleared
    step(4'b0010, 1'b1, 3'd0, 1'b0, 3'd0, "R6");
    rd(3'd1, "R6"); rd(3'd4, "R3");
    // R7 simultaneous strobes share one time
    step(4'b1001, 1'b0, 3'd0, 1'b0, 3'd0, "R7");
    rd(3'd0, "R7"); rd(3'd3, "R7");
    t_a = m_ts[0];
    check("R7 same", m_ts[3], t_a);
    // R9 unmapped addresses read zero
    for (int a = 5; a < 8; a++) rd(3'(a), "R9");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] stb;
      logic       wr;
      logic [2:0] wa, ra;
      logic       r;
      stb = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
      wr  = (($urandom % 24) == 0);
      wa  = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom);
      r   = (($urandom % 2) == 0);
      ra  = 3'($urandom % 6);
      step(stb, wr, wa, r, ra, (ra < 3'd4) ? "R4 R5 random" : "R3 R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule